// File: doc/BRIEF.md
# Programmable CRC Engine With Narrow-Width Modes

This block computes a non-reflected, MSB-first cyclic redundancy check over a byte stream. It does so with one 32-bit shift register, a programmable generator polynomial, a programmable preset value and a programmable output XOR. A width code selects an 8-, 16- or 32-bit result from the same datapath. Narrow polynomials and presets are supplied right-aligned on the configuration pins. The engine moves them to the top of the register and zero-fills the low bits. The finished remainder is then shifted back down, so the result appears in the low bits of the output. Either or both reflected conventions are available: each byte can be bit-reversed on the way in, and the N-bit result can be bit-reversed on the way out.

Bytes enter on a valid/ready stream that carries a first-byte marker and a last-byte marker. The engine takes one byte in every cycle and never applies back-pressure. `in_ready` is low only while reset is asserted and is high on every cycle after the first clock edge that follows reset release. A byte is transferred on any rising edge where `in_valid` and `in_ready` are both high. The sender may insert idle cycles between bytes at will.

The configuration pins are captured together with the first byte of a message and hold for that whole message. When the last byte is transferred, the engine pulses `crc_done` for one cycle in the following cycle and updates `crc_value` in that same cycle. A new message may begin in the very cycle in which the previous result is being reported.

Top module: `crc_stream_engine`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `crc_done` are 0 and `crc_value` is 0. From the first clock edge after reset release, `in_ready` stays 1.
- R2: With width code 2'b10 (or 2'b11), the result is the 32-bit MSB-first CRC. Each transferred byte is XORed into register bits 31:24 and is followed by eight shift-left steps, which XOR in the polynomial whenever the bit shifted out is 1. Idle cycles (`in_valid` low) inside a message do not change the result.
- R3: With width code 2'b00, `cfg_poly[7:0]` and `cfg_init[7:0]` serve as an 8-bit CRC. The result equals the native 8-bit CRC, is placed in `crc_value[7:0]`, and has `crc_value[31:8]` equal to 0.
- R4: With width code 2'b01, `cfg_poly[15:0]` and `cfg_init[15:0]` serve as a 16-bit CRC. The result is placed in `crc_value[15:0]`, with the upper 16 bits equal to 0.
- R5: When `cfg_refl_in` is 1, the bits of every byte are reversed (bit 0 becomes bit 7) before the byte enters the register.
- R6: When `cfg_refl_out` is 1, the N-bit result is bit-reversed. The low N bits of `cfg_xor_out` are then XORed onto the N-bit result in every mode.
- R7: A byte with `in_first` set reloads the preset before it is absorbed. A first-marked byte that arrives inside an unfinished message discards that message.
- R8: All configuration pins are sampled on the first-marked byte. Changes to them later in the message have no effect on the result.
- R9: `crc_done` is high for exactly the one cycle after the transfer of a last-marked byte. `crc_value` changes only in cycles where `crc_done` is high, and it holds the result until the next one.
- R10: A byte transferred with no message open and without `in_first` is ignored: it produces no `crc_done`, even if `in_last` is set, and `crc_value` is unchanged.
- R11: A byte with both `in_first` and `in_last` set is a complete one-byte message.
- R12: A first-marked byte may be transferred in the cycle right after a last-marked byte. The earlier result is reported unchanged in that cycle, and the new message uses its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Result width: 00 = 8, 01 = 16, 10/11 = 32 |
| cfg_poly | input | 32 | Generator polynomial, right-aligned to the width |
| cfg_init | input | 32 | Preset value, right-aligned to the width |
| cfg_xor_out | input | 32 | Output XOR, low N bits used |
| cfg_refl_in | input | 1 | Reverse the bits of each input byte |
| cfg_refl_out | input | 1 | Reverse the N-bit result before the output XOR |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| in_data | input | 8 | Message byte |
| in_first | input | 1 | Byte starts a message |
| in_last | input | 1 | Byte ends a message |
| crc_done | output | 1 | One-cycle pulse: `crc_value` holds a new result |
| crc_value | output | 32 | Right-aligned conditioned result |

## Verification
The case where two operations fall in the same cycle is the handover between messages. The result of one message is conditioned and reported while the first byte of the next message reloads the preset and captures a different width, polynomial and set of reflection flags. The bench provokes this by driving the next message's first byte, with a changed configuration, in the cycle right after the previous last byte. In that same cycle it compares the reported value against a bit-serial native-width model of the earlier message. It then checks the second result against the model under the new configuration. A one-byte message, with first and last on the same byte, followed at once by another is checked the same way.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    WSEL_8  = 2'b00,
    WSEL_16 = 2'b01,
    WSEL_32 = 2'b10
  } crc_wsel_e;

  typedef struct packed {
    logic [1:0]       wsel;
    logic [REG_W-1:0] poly;
    logic [REG_W-1:0] init;
    logic [REG_W-1:0] xor_out;
    logic             refl_in;
    logic             refl_out;
  } crc_cfg_t;

  // Number of result bits selected by a width code; code 3 acts as full width.
  function automatic int unsigned wsel_bits(input logic [1:0] w);
    if (w == WSEL_8)       return 8;
    else if (w == WSEL_16) return 16;
    else                   return REG_W;
  endfunction

  // Move a right-aligned narrow value to the top of the register.
  function automatic logic [REG_W-1:0] to_top(input logic [REG_W-1:0] v,
                                              input logic [1:0] w);
    return v << (REG_W - wsel_bits(w));
  endfunction

  function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] flip_word(input logic [REG_W-1:0] b);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) r[i] = b[REG_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/crc_cfg_hold.sv
module crc_cfg_hold
  import crc_eng_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take_i,
  input  logic     first_i,
  input  logic     last_i,
  input  crc_cfg_t live_i,
  output crc_cfg_t eff_o,
  output logic     open_o
);

  crc_cfg_t held_q;
  logic     open_q;
  logic     load;

  assign load   = take_i & first_i;
  assign eff_o  = load ? live_i : held_q;
  assign open_o = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      open_q <= 1'b0;
    end else begin
      if (load) held_q <= live_i;
      if (take_i) open_q <= ~last_i;
    end
  end

  // R8: captured settings only move when a message starts
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_q));

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_eng_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int BW = BYTE_W
) (
  input  logic [RW-1:0] state_i,
  input  logic [BW-1:0] data_i,
  input  logic [RW-1:0] poly_i,
  output logic [RW-1:0] state_o
);

  localparam int PAD_W = RW - BW;

  logic [RW-1:0] chain [0:BW];

  assign chain[0] = state_i ^ {data_i, {PAD_W{1'b0}}};

  for (genvar g = 0; g < BW; g++) begin : g_shift
    assign chain[g+1] = chain[g][RW-1] ? ((chain[g] << 1) ^ poly_i)
                                       :  (chain[g] << 1);
  end

  assign state_o = chain[BW];

endmodule

// File: rtl/crc_out_cond.sv
module crc_out_cond
  import crc_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [REG_W-1:0] state_i,
  input  logic [1:0]       wsel_i,
  input  logic             refl_out_i,
  input  logic [REG_W-1:0] xor_out_i,
  output logic             done_o,
  output logic [REG_W-1:0] value_o
);

  int unsigned      nbits;
  logic [REG_W-1:0] low_al;
  logic [REG_W-1:0] ordered;
  logic [REG_W-1:0] keep;
  logic [REG_W-1:0] result;
  logic             done_q;
  logic [REG_W-1:0] value_q;
  logic [1:0]       wsel_q;

  always_comb begin
    nbits   = wsel_bits(wsel_i);
    low_al  = state_i >> (REG_W - nbits);
    ordered = refl_out_i ? (flip_word(low_al) >> (REG_W - nbits)) : low_al;
    keep    = (nbits == REG_W) ? '1 : ((REG_W'(1) << nbits) - REG_W'(1));
    result  = (ordered ^ xor_out_i) & keep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      value_q <= '0;
      wsel_q  <= WSEL_32;
    end else begin
      done_q <= fire_i;
      if (fire_i) begin
        value_q <= result;
        wsel_q  <= wsel_i;
      end
    end
  end

  assign done_o  = done_q;
  assign value_o = value_q;

  // R3: an 8-bit result leaves the upper bits clear
  p_narrow8_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && wsel_q == WSEL_8) |-> (value_q[REG_W-1:8] == '0));

  // R4: a 16-bit result leaves the upper half clear
  p_narrow16_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && wsel_q == WSEL_16) |-> (value_q[REG_W-1:16] == '0));

endmodule

// File: rtl/crc_stream_engine.sv
module crc_stream_engine
  import crc_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_width,
  input  logic [REG_W-1:0] cfg_poly,
  input  logic [REG_W-1:0] cfg_init,
  input  logic [REG_W-1:0] cfg_xor_out,
  input  logic             cfg_refl_in,
  input  logic             cfg_refl_out,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic             in_first,
  input  logic             in_last,
  output logic             crc_done,
  output logic [REG_W-1:0] crc_value
);

  crc_cfg_t          live_cfg;
  crc_cfg_t          eff_cfg;
  logic              rdy_q;
  logic              xfer;
  logic              take;
  logic              fin;
  logic              msg_open;
  logic [REG_W-1:0]  crc_q;
  logic [REG_W-1:0]  base;
  logic [REG_W-1:0]  poly_top;
  logic [BYTE_W-1:0] byte_in;
  logic [REG_W-1:0]  next_state;

  assign live_cfg = '{wsel: cfg_width, poly: cfg_poly, init: cfg_init,
                      xor_out: cfg_xor_out, refl_in: cfg_refl_in,
                      refl_out: cfg_refl_out};

  assign in_ready = rdy_q;
  assign xfer     = in_valid & rdy_q;
  assign take     = xfer & (in_first | msg_open);
  assign fin      = take & in_last;

  crc_cfg_hold u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .first_i (in_first),
    .last_i  (in_last),
    .live_i  (live_cfg),
    .eff_o   (eff_cfg),
    .open_o  (msg_open)
  );

  assign base     = in_first ? to_top(eff_cfg.init, eff_cfg.wsel) : crc_q;
  assign poly_top = to_top(eff_cfg.poly, eff_cfg.wsel);
  assign byte_in  = eff_cfg.refl_in ? flip_byte(in_data) : in_data;

  crc_byte_step #(.RW(REG_W), .BW(BYTE_W)) u_step (
    .state_i (base),
    .data_i  (byte_in),
    .poly_i  (poly_top),
    .state_o (next_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      crc_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (take) crc_q <= next_state;
    end
  end

  crc_out_cond u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fin),
    .state_i    (next_state),
    .wsel_i     (eff_cfg.wsel),
    .refl_out_i (eff_cfg.refl_out),
    .xor_out_i  (eff_cfg.xor_out),
    .done_o     (crc_done),
    .value_o    (crc_value)
  );

  // R1: once ready, the engine never withdraws it
  p_ready_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R9: every done pulse follows a transferred closing byte
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> $past(fin));

  // R9: the result only moves together with a done pulse
  p_value_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_value) |-> crc_done);

  // R10: a stray byte outside a message yields no done
  p_stray_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !in_first && !msg_open) |=> !crc_done);

endmodule

// File: tb/sim_crc_stream_engine.sv
`timescale 1ns/1ps
module sim_crc_stream_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'b10;
  logic [31:0] cfg_poly = '0, cfg_init = '0, cfg_xor_out = '0;
  logic        cfg_refl_in = 1'b0, cfg_refl_out = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, crc_done;
  logic [31:0] crc_value;

  int checks = 0;
  int failures = 0;
  logic [7:0] msg [0:63];

  always #2.5 clk = ~clk;

  crc_stream_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_poly(cfg_poly),
    .cfg_init(cfg_init), .cfg_xor_out(cfg_xor_out), .cfg_refl_in(cfg_refl_in),
    .cfg_refl_out(cfg_refl_out), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .crc_done(crc_done), .crc_value(crc_value)
  );

  // Check vectors over the ASCII digits 1..9
  localparam int NV = 6;
  localparam logic [1:0]  TV_W    [NV] = '{2'b10, 2'b01, 2'b00, 2'b01, 2'b10, 2'b00};
  localparam logic [31:0] TV_POLY [NV] = '{32'h04C11DB7, 32'h1021, 32'h07, 32'h8005, 32'h04C11DB7, 32'h31};
  localparam logic [31:0] TV_INIT [NV] = '{32'hFFFFFFFF, 32'hFFFF, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0};
  localparam logic [31:0] TV_XOR  [NV] = '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0};
  localparam logic        TV_RI   [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        TV_RO   [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] TV_EXP  [NV] = '{32'hCBF43926, 32'h29B1, 32'hF4, 32'hBB3D, 32'hFC891918, 32'hA1};
  localparam string       TV_TAG  [NV] = '{"R2", "R4", "R3", "R4", "R2", "R3"};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  // Native-width bit-serial reference
  function automatic logic [31:0] model(input int n, input logic [31:0] poly,
      input logic [31:0] init, input logic [31:0] xo, input logic ri,
      input logic ro, input int len);
    logic [31:0] mask, r, t;
    logic [7:0]  b;
    logic        fb;
    mask = (n == 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 32'h1);
    r = init & mask;
    for (int k = 0; k < len; k++) begin
      b = msg[k];
      if (ri) for (int i = 0; i < 8; i++) b[i] = msg[k][7-i];
      for (int i = 7; i >= 0; i--) begin
        fb = r[n-1] ^ b[i];
        r = (r << 1) & mask;
        if (fb) r = r ^ (poly & mask);
      end
    end
    if (ro) begin
      t = '0;
      for (int i = 0; i < n; i++) t[i] = r[n-1-i];
      r = t;
    end
    return (r ^ xo) & mask;
  endfunction

  task automatic set_cfg(input logic [1:0] w, input logic [31:0] p, input logic [31:0] i,
                         input logic [31:0] x, input logic ri, input logic ro);
    cfg_width = w; cfg_poly = p; cfg_init = i; cfg_xor_out = x;
    cfg_refl_in = ri; cfg_refl_out = ro;
  endtask

  // Called at a falling edge; returns at the falling edge after the transfer.
  task automatic put(input logic [7:0] b, input logic f, input logic l);
    in_valid = 1'b1; in_data = b; in_first = f; in_last = l;
    @(negedge clk);
    in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_data = 8'hEE; in_first = 1'b0; in_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int len);
    for (int k = 0; k < len; k++) put(msg[k], k == 0, k == len - 1);
  endtask

  task automatic load_str(input string s);
    for (int k = 0; k < s.len(); k++) msg[k] = s[k];
  endtask

  int wd_done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (wd_done == 0) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] e1, e2, hold;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, in_ready}, 32'h0);
    chk("R1 done in reset", {31'b0, crc_done}, 32'h0);
    chk("R1 value in reset", crc_value, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, in_ready}, 32'h1);

    // Table walk
    load_str("123456789");
    for (int v = 0; v < NV; v++) begin
      set_cfg(TV_W[v], TV_POLY[v], TV_INIT[v], TV_XOR[v], TV_RI[v], TV_RO[v]);
      send(9);
      chk({TV_TAG[v], " table done"}, {31'b0, crc_done}, 32'h1);
      chk({TV_TAG[v], " table value"}, crc_value, TV_EXP[v]);
      idle(1);
    end

    // R3: 8-bit mode on a text message
    load_str("a sample string");
    set_cfg(2'b00, 32'hB7, 32'h0, 32'h0, 1'b0, 1'b0);
    send(15);
    chk("R3 narrow8", crc_value, model(8, 32'hB7, 0, 0, 0, 0, 15));
    idle(1);

    // R5/R6: input reflection only, 16-bit, partial xor
    set_cfg(2'b01, 32'h3D65, 32'h1D0F, 32'h00FF, 1'b1, 1'b0);
    send(15);
    chk("R5 refl in", crc_value, model(16, 32'h3D65, 32'h1D0F, 32'h00FF, 1, 0, 15));
    idle(1);

    // R6: output reflection only, 32-bit
    set_cfg(2'b10, 32'h1EDC6F41, 32'h12345678, 32'hA5A5A5A5, 1'b0, 1'b1);
    send(15);
    chk("R6 refl out", crc_value, model(32, 32'h1EDC6F41, 32'h12345678, 32'hA5A5A5A5, 0, 1, 15));
    // R9: pulse lasts one cycle, value held
    hold = crc_value;
    idle(1);
    chk("R9 done drops", {31'b0, crc_done}, 32'h0);
    chk("R9 value held", crc_value, hold);

    // R2: idle gaps inside a message
    set_cfg(2'b10, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1);
    load_str("123456789");
    for (int k = 0; k < 9; k++) begin
      put(msg[k], k == 0, k == 8);
      if (k != 8) idle(k % 3);
    end
    chk("R2 gaps", crc_value, 32'hCBF43926);
    idle(1);

    // R8: config changes after the first byte are ignored
    set_cfg(2'b01, 32'h1021, 32'hFFFF, 32'h0, 1'b0, 1'b0);
    put(msg[0], 1'b1, 1'b0);
    set_cfg(2'b00, 32'h07, 32'h55, 32'hFF, 1'b1, 1'b1);
    for (int k = 1; k < 9; k++) put(msg[k], 1'b0, k == 8);
    chk("R8 cfg frozen", crc_value, 32'h29B1);
    idle(1);

    // R7: restart mid-message discards earlier bytes
    set_cfg(2'b00, 32'h07, 32'h0, 32'h0, 1'b0, 1'b0);
    put(8'hDE, 1'b1, 1'b0); put(8'hAD, 1'b0, 1'b0); put(8'hBE, 1'b0, 1'b0);
    send(9);
    chk("R7 restart", crc_value, 32'hF4);
    hold = crc_value;
    idle(2);

    // R10: stray closing byte outside a message
    put(8'h5A, 1'b0, 1'b1);
    chk("R10 stray no done", {31'b0, crc_done}, 32'h0);
    idle(1);
    chk("R10 stray value", crc_value, hold);

    // R11: one-byte message
    msg[0] = 8'hC3;
    set_cfg(2'b01, 32'h8005, 32'hFFFF, 32'h0, 1'b1, 1'b1);
    put(8'hC3, 1'b1, 1'b1);
    chk("R11 single done", {31'b0, crc_done}, 32'h1);
    chk("R11 single value", crc_value, model(16, 32'h8005, 32'hFFFF, 0, 1, 1, 1));
    idle(1);

    // R12: back-to-back messages with different configurations
    load_str("123456789");
    set_cfg(2'b10, 32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0);
    send(9);
    e1 = 32'hFC891918;
    load_str("Zq");
    set_cfg(2'b00, 32'h31, 32'hFF, 32'h0F, 1'b1, 1'b0);
    e2 = model(8, 32'h31, 32'hFF, 32'h0F, 1, 0, 2);
    in_valid = 1'b1; in_data = msg[0]; in_first = 1'b1; in_last = 1'b0;
    #0.1;
    chk("R12 prior done", {31'b0, crc_done}, 32'h1);
    chk("R12 prior value", crc_value, e1);
    @(negedge clk);
    put(msg[1], 1'b0, 1'b1);
    chk("R12 next value", crc_value, e2);
    // immediate single-byte follow-on
    msg[0] = 8'h00;
    set_cfg(2'b01, 32'h1021, 32'h0, 32'h0, 1'b0, 1'b0);
    put(8'h00, 1'b1, 1'b1);
    chk("R12 follow-on done", {31'b0, crc_done}, 32'h1);
    chk("R12 follow-on value", crc_value, model(16, 32'h1021, 0, 0, 0, 0, 1));
    idle(2);

    wd_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule